// File: doc/BRIEF.md
# Stop Grant Acknowledge Counter

This block sits between the processor-bus snooping logic and the message sender that talks to the I/O hub. Every hardware thread that enters its stop state puts its own stop-grant transaction on the bus. The bus decoder turns each of those transactions into a one-cycle `grant_pulse`. The block counts these pulses. When the programmed number has arrived, it raises a request for one acknowledge message, and it holds that request until the hub-side sender accepts it with `ack_ready`.

The number of grants to wait for comes from a 3-bit code, and software writes it once per reset. Code `3'b000` asks for one grant per acknowledge. Code `3'b001` asks for two, which suits a processor with two enabled threads. The six other codes are reserved: the block stores them, uses a threshold of one, and sets a sticky error flag. Only the first configuration write after reset is accepted. Any later write changes nothing and sets a sticky lock-violation flag. A `stopclk_start` pulse marks the beginning of a new stop-clock sequence and discards any partial count.

Reset is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset a few cycles after `rst_n` rises.

Top module: `sgack_unit`

## Requirements
- R1: After reset, `ack_req`, `cfg_rsvd_err` and `cfg_lock_err` are 0, the count is empty, and the threshold is one grant until a configuration is written.
- R2: With code `3'b000`, each grant pulse sampled on a clock edge raises `ack_req` right after that same edge.
- R3: With code `3'b001`, the first grant pulse raises no request and the second one does.
- R4: Grant pulses need not be adjacent. A partial count is held for any number of idle cycles between pulses.
- R5: A written code in the range `3'b010` to `3'b111` acts as a threshold of one. It sets `cfg_rsvd_err` the cycle after the write, and the flag stays set until reset.
- R6: The first `cfg_wr` after reset sets the code. Every later `cfg_wr` leaves the code and `cfg_rsvd_err` unchanged and sets the sticky `cfg_lock_err` the cycle after.
- R7: While `ack_ready` is 0, a raised `ack_req` stays at 1. It is accepted on the first edge where `ack_ready` is 1, and it falls after that edge unless a further acknowledge is owed.
- R8: Grants that arrive while a request is pending count toward the next acknowledge, and the count saturates at the threshold. If the threshold was reached while pending, `ack_req` stays high across the acceptance edge, and exactly one further acknowledge follows.
- R9: Issuing an acknowledge clears the count to zero. A later acknowledge needs a full threshold of new grants.
- R10: A `stopclk_start` pulse discards a partial count.
- R11: A grant pulse in the same cycle as `stopclk_start` counts as the first grant of the new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Grant-count code to write |
| grant_pulse | input | 1 | One pulse per observed stop-grant transaction |
| stopclk_start | input | 1 | Start of a stop-clock sequence; clears the partial count |
| ack_ready | input | 1 | Hub-side sender accepts the pending request |
| ack_req | output | 1 | Acknowledge message request |
| cfg_rsvd_err | output | 1 | Sticky: a reserved code was written |
| cfg_lock_err | output | 1 | Sticky: a write came after the configuration was locked |

## Verification
The design has one register stage from input to output. A grant or configuration write sampled on an edge shows up on `ack_req` or an error flag right after that edge. The bench drives inputs on the falling edge, so each stimulus is sampled on the next rising edge. It reads outputs on the falling edge that follows, which is half a period after the expected change. Accepted handshakes are counted on rising edges from the values present before the edge, so each acceptance is credited to the edge where it takes effect. Each task checks the handshake count as a difference over its own scenario. Stimulus starts only after the two-stage reset synchroniser has released.

// File: rtl/sgack_pkg.sv
package sgack_pkg;

  // Width of the grant-count configuration code.
  localparam int unsigned CODE_W = 3;

  // Largest number of grants that any defined code asks for.
  localparam int unsigned MAX_GRANTS = 2;

  // Width of the grant counter; it must hold MAX_GRANTS itself.
  localparam int unsigned CNT_W = $clog2(MAX_GRANTS + 1);

  // The highest defined code value; every code above it is reserved.
  localparam int unsigned LAST_DEFINED_CODE = 1;

  // Stages in the reset-release synchroniser.
  localparam int unsigned RST_STAGES = 2;

  // Defined code values.
  typedef enum logic [CODE_W-1:0] {
    GC_ONE_GRANT  = 3'b000,
    GC_TWO_GRANTS = 3'b001
  } grant_code_e;

endpackage

// File: rtl/sgack_rst_sync.sv
module sgack_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  generate
    if (STAGES < 2) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= 1'b1;
      end
      assign rst_n_sync = q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end
      assign rst_n_sync = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/sgack_cfg.sv
module sgack_cfg #(
  parameter int unsigned CODE_W    = 3,
  parameter int unsigned LAST_CODE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CODE_W-1:0] wdata,
  output logic [CODE_W-1:0] code,
  output logic              rsvd_err,
  output logic              lock_err
);

  localparam logic [CODE_W-1:0] LAST_VAL = CODE_W'(LAST_CODE);

  logic [CODE_W-1:0] code_q, code_d;
  logic              locked_q, locked_d;
  logic              rsvd_q, rsvd_d;
  logic              lerr_q, lerr_d;
  logic              wdata_rsvd;
  logic              reg_en;

  always_comb wdata_rsvd = (wdata > LAST_VAL);

  // Next state: one write is accepted per reset, and every later write is refused.
  always_comb begin
    code_d   = code_q;
    locked_d = locked_q;
    rsvd_d   = rsvd_q;
    lerr_d   = lerr_q;
    if (wr) begin
      if (!locked_q) begin
        code_d   = wdata;
        locked_d = 1'b1;
        if (wdata_rsvd) rsvd_d = 1'b1;
      end else begin
        lerr_d = 1'b1;
      end
    end
  end

  always_comb reg_en = wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      locked_q <= 1'b0;
      rsvd_q   <= 1'b0;
      lerr_q   <= 1'b0;
    end else if (reg_en) begin
      code_q   <= code_d;
      locked_q <= locked_d;
      rsvd_q   <= rsvd_d;
      lerr_q   <= lerr_d;
    end
  end

  assign code     = code_q;
  assign rsvd_err = rsvd_q;
  assign lock_err = lerr_q;

endmodule

// File: rtl/sgack_count.sv
module sgack_count #(
  parameter int unsigned CODE_W = 3,
  parameter int unsigned CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              grant,
  input  logic              seq_start,
  input  logic              ready,
  output logic              req
);

  localparam logic [CNT_W:0]      THR_ONE  = (CNT_W+1)'(1);
  localparam logic [CNT_W:0]      THR_TWO  = (CNT_W+1)'(2);
  localparam logic [CODE_W-1:0]   CODE_TWO = CODE_W'(sgack_pkg::GC_TWO_GRANTS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic [CNT_W:0]   thresh;
  logic [CNT_W:0]   base;
  logic [CNT_W:0]   sum;
  logic [CNT_W:0]   sum_sat;
  logic             accept;
  logic             slot_free;
  logic             fire;
  logic             cnt_en;

  // Decode the grant threshold. Reserved codes fall back to one grant.
  always_comb begin
    if (code == CODE_TWO) thresh = THR_TWO;
    else                  thresh = THR_ONE;
  end

  always_comb begin
    accept    = req_q & ready;
    slot_free = ~req_q | accept;
    base      = seq_start ? '0 : {1'b0, cnt_q};
    sum       = base + {{CNT_W{1'b0}}, grant};
    sum_sat   = (sum > thresh) ? thresh : sum;
    fire      = slot_free & (sum_sat >= thresh);
    req_d     = fire | (req_q & ~ready);
    cnt_d     = fire ? '0 : sum_sat[CNT_W-1:0];
    cnt_en    = grant | seq_start | fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req = req_q;

endmodule

// File: rtl/sgack_unit.sv
module sgack_unit #(
  parameter int unsigned CODE_W     = sgack_pkg::CODE_W,
  parameter int unsigned MAX_GRANTS = sgack_pkg::MAX_GRANTS,
  parameter int unsigned LAST_CODE  = sgack_pkg::LAST_DEFINED_CODE,
  parameter int unsigned RST_STAGES = sgack_pkg::RST_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CODE_W-1:0] cfg_wdata,
  input  logic              grant_pulse,
  input  logic              stopclk_start,
  input  logic              ack_ready,
  output logic              ack_req,
  output logic              cfg_rsvd_err,
  output logic              cfg_lock_err
);

  localparam int unsigned CNT_W = $clog2(MAX_GRANTS + 1);

  logic              rst_n_int;
  logic [CODE_W-1:0] code;

  sgack_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sgack_cfg #(.CODE_W(CODE_W), .LAST_CODE(LAST_CODE)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr       (cfg_wr),
    .wdata    (cfg_wdata),
    .code     (code),
    .rsvd_err (cfg_rsvd_err),
    .lock_err (cfg_lock_err)
  );

  sgack_count #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .code      (code),
    .grant     (grant_pulse),
    .seq_start (stopclk_start),
    .ready     (ack_ready),
    .req       (ack_req)
  );

endmodule

// File: rtl/sgack_unit_chk.sv
module sgack_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_wr,
  input logic grant_pulse,
  input logic ack_ready,
  input logic ack_req,
  input logic cfg_rsvd_err,
  input logic cfg_lock_err
);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !ack_ready) |=> ack_req);

  p_rise_needs_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_req) |-> $past(grant_pulse));

  p_rsvd_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rsvd_err |=> cfg_rsvd_err);

  p_rsvd_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rsvd_err) |-> $past(cfg_wr));

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock_err |=> cfg_lock_err);

  p_lock_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_lock_err) |-> $past(cfg_wr));

endmodule

bind sgack_unit sgack_unit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr       (cfg_wr),
  .grant_pulse  (grant_pulse),
  .ack_ready    (ack_ready),
  .ack_req      (ack_req),
  .cfg_rsvd_err (cfg_rsvd_err),
  .cfg_lock_err (cfg_lock_err)
);

// File: tb/sgack_unit_tb.sv
module sgack_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr;
  logic [2:0] cfg_wdata;
  logic       grant_pulse;
  logic       stopclk_start;
  logic       ack_ready;
  logic       ack_req;
  logic       cfg_rsvd_err;
  logic       cfg_lock_err;

  int checks = 0;
  int fails  = 0;
  int acks   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgack_unit u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr        (cfg_wr),
    .cfg_wdata     (cfg_wdata),
    .grant_pulse   (grant_pulse),
    .stopclk_start (stopclk_start),
    .ack_ready     (ack_ready),
    .ack_req       (ack_req),
    .cfg_rsvd_err  (cfg_rsvd_err),
    .cfg_lock_err  (cfg_lock_err)
  );

  // Accepted handshakes, counted from values held before each rising edge.
  always @(posedge clk) if (rst_n && ack_req && ack_ready) acks <= acks + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; grant_pulse = 1'b0;
    stopclk_start = 1'b0; ack_ready = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(4);
  endtask

  task automatic write_cfg(input logic [2:0] c);
    cfg_wr = 1'b1; cfg_wdata = c;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic grant_once();
    grant_pulse = 1'b1;
    @(negedge clk);
    grant_pulse = 1'b0;
  endtask

  task automatic start_once(input logic with_grant);
    stopclk_start = 1'b1; grant_pulse = with_grant;
    @(negedge clk);
    stopclk_start = 1'b0; grant_pulse = 1'b0;
  endtask

  task automatic t_reset_state();
    int base;
    reset_dut();
    chk("R1 ack_req after reset", ack_req, 0);
    chk("R1 rsvd_err after reset", cfg_rsvd_err, 0);
    chk("R1 lock_err after reset", cfg_lock_err, 0);
    base = acks;
    grant_once();
    chk("R1 default threshold one", ack_req, 1);
    idle(2);
    chk("R1 one ack accepted", acks - base, 1);
  endtask

  task automatic t_code_one();
    int base;
    reset_dut();
    write_cfg(3'b000);
    base = acks;
    grant_once();
    chk("R2 req after single grant", ack_req, 1);
    @(negedge clk);
    chk("R2 req drops after accept", ack_req, 0);
    grant_once();
    chk("R2 second grant second req", ack_req, 1);
    idle(2);
    chk("R2 two acks", acks - base, 2);
  endtask

  task automatic t_code_two();
    int base;
    reset_dut();
    write_cfg(3'b001);
    base = acks;
    grant_once();
    chk("R3 no req after first grant", ack_req, 0);
    idle(5);
    chk("R4 partial count held idle", ack_req, 0);
    grant_once();
    chk("R3 req after second grant", ack_req, 1);
    idle(2);
    chk("R4 one ack for spaced grants", acks - base, 1);
  endtask

  task automatic t_reserved();
    int base;
    reset_dut();
    write_cfg(3'b110);
    chk("R5 rsvd_err set", cfg_rsvd_err, 1);
    chk("R5 lock_err clear", cfg_lock_err, 0);
    base = acks;
    grant_once();
    chk("R5 reserved acts as one", ack_req, 1);
    idle(3);
    chk("R5 rsvd_err sticky", cfg_rsvd_err, 1);
    chk("R5 one ack", acks - base, 1);
  endtask

  task automatic t_lock();
    reset_dut();
    write_cfg(3'b001);
    chk("R6 no lock_err on first write", cfg_lock_err, 0);
    write_cfg(3'b000);
    chk("R6 lock_err on second write", cfg_lock_err, 1);
    write_cfg(3'b111);
    chk("R6 reserved after lock ignored", cfg_rsvd_err, 0);
    grant_once();
    chk("R6 code kept at two grants", ack_req, 0);
    grant_once();
    chk("R6 second grant fires", ack_req, 1);
    idle(2);
    chk("R6 lock_err sticky", cfg_lock_err, 1);
  endtask

  task automatic t_hold();
    int base;
    reset_dut();
    write_cfg(3'b000);
    ack_ready = 1'b0;
    base = acks;
    grant_once();
    chk("R7 req raised", ack_req, 1);
    idle(4);
    chk("R7 req held while busy", ack_req, 1);
    chk("R7 no accept while busy", acks - base, 0);
    ack_ready = 1'b1;
    @(negedge clk);
    chk("R7 req drops after accept", ack_req, 0);
    chk("R7 exactly one ack", acks - base, 1);
  endtask

  task automatic t_pending();
    int base;
    reset_dut();
    write_cfg(3'b001);
    ack_ready = 1'b0;
    base = acks;
    grant_once();
    grant_once();
    chk("R8 first req pending", ack_req, 1);
    for (int i = 0; i < 3; i++) grant_once();
    chk("R8 no accept while busy", acks - base, 0);
    ack_ready = 1'b1;
    @(negedge clk);
    chk("R8 req stays high for owed ack", ack_req, 1);
    @(negedge clk);
    chk("R8 req drops after owed ack", ack_req, 0);
    idle(3);
    chk("R8 exactly two acks with saturation", acks - base, 2);
  endtask

  task automatic t_clear_after_ack();
    int base;
    reset_dut();
    write_cfg(3'b001);
    base = acks;
    grant_once();
    grant_once();
    chk("R9 ack after two grants", ack_req, 1);
    grant_once();
    idle(3);
    chk("R9 one new grant not enough", ack_req, 0);
    grant_once();
    chk("R9 full new threshold fires", ack_req, 1);
    idle(2);
    chk("R9 two acks total", acks - base, 2);
  endtask

  task automatic t_seq_start();
    reset_dut();
    write_cfg(3'b001);
    grant_once();
    start_once(1'b0);
    grant_once();
    chk("R10 partial count discarded", ack_req, 0);
    grant_once();
    chk("R10 fires after full new count", ack_req, 1);
    idle(2);
    grant_once();
    start_once(1'b1);
    chk("R11 start with grant no fire", ack_req, 0);
    grant_once();
    chk("R11 simultaneous grant counted", ack_req, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; grant_pulse = 1'b0;
    stopclk_start = 1'b0; ack_ready = 1'b1;
    t_reset_state();
    t_code_one();
    t_code_two();
    t_reserved();
    t_lock();
    t_hold();
    t_pending();
    t_clear_after_ack();
    t_seq_start();
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule